// File: doc/BRIEF.md
# Segmented Word Stack Engine

The engine keeps a 16-bit stack segment and a 16-bit stack pointer and carries out push and pop commands on 16-bit words held in a byte-wide memory. Each byte address it presents is a 20-bit physical address: the segment shifted left by four bits plus the byte offset, wrapped modulo 2^20. The stack grows toward lower addresses. The pointer always names the word pushed last, so every word at or above the pointer is live stack data.

A push first lowers the pointer by two and then writes the word little-endian, low byte first. A pop reads the low byte and then the high byte at the pointer, raises the pointer by two and returns the word with a one-cycle done strobe. The empty stack is the pointer value 0000h. The first push lands at offset FFFEh, and the lowest usable word sits at offset 0002h. A pop of an empty stack and a push onto a full stack both finish at once with an error flag. In either case the pointer does not move and the memory is not touched.

Software or the surrounding core sets the segment and pointer through a configuration load while the engine is idle. It then issues one command at a time and waits for done.

Top module: `seg_stack_engine`

## Requirements
- R1: Every memory address equals (segment << 4) + byte offset, truncated to 20 bits, so segment FFFFh with offset FFFEh gives 0FFEEh.
- R2: A push with the pointer not at 0002h lowers the pointer by 2, then writes bits 7:0 of the word at the new pointer and in the next port cycle bits 15:8 at the new pointer plus 1.
- R3: A pop with the pointer not at 0000h reads the byte at the pointer into bits 7:0 and the byte at pointer plus 1 into bits 15:8. It then raises the pointer by 2 and presents the word on pop_word while done is high.
- R4: After reset the segment and the pointer are 0000h, busy and done are low, and the first push writes offsets FFFEh and FFFFh.
- R5: A pop while the pointer is 0000h ends with done and underflow high, leaves the pointer unchanged and issues no memory read.
- R6: A push while the pointer is 0002h ends with done and overflow high, leaves the pointer unchanged and issues no memory write.
- R7: A command is taken only while busy is low. cmd_valid during a busy command has no effect on the pointer, the memory or the number of done pulses.
- R8: Each command gives exactly one one-cycle done pulse. Each byte write takes one mem_we cycle. A read waits for mem_rvalid however many cycles it takes, and mem_we and mem_re are never high together.
- R9: cfg_load while idle and without cmd_valid loads the segment from cfg_seg and the pointer from cfg_ptr with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_wdata | input | 16 | Word to push |
| cfg_load | input | 1 | Load segment and pointer |
| cfg_seg | input | 16 | Segment value to load |
| cfg_ptr | input | 16 | Pointer value to load (bit 0 ignored) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| pop_word | output | 16 | Popped word, valid with done |
| overflow | output | 1 | Push refused, valid with done |
| underflow | output | 1 | Pop refused, valid with done |
| sp_out | output | 16 | Current stack pointer |
| ss_out | output | 16 | Current stack segment |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Byte write enable |
| mem_re | output | 1 | Byte read request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read back |
| mem_rvalid | input | 1 | mem_rdata is valid |

## Verification
The hardest states to reach are the two pointer limits. A full stack needs 32767 pushes from empty, and a wrapped physical address needs a segment near the top of the space. The stimulus jumps to both through the configuration load: a pointer of 0006h reaches the full limit in two pushes, and segment FFFFh forces the 20-bit wrap. A memory model with a variable read delay and command requests injected during busy cover the handshake and the refusal of commands while busy.

// File: rtl/ssk_pkg.sv
package ssk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_RWAIT = 3'd3,
    ST_FIN   = 3'd4
  } ssk_state_e;
endpackage

// File: rtl/ssk_addr_gen.sv
module ssk_addr_gen #(
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int PHYS_W = OFF_W + SHIFT
) (
  input  logic [OFF_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [PHYS_W-1:0] phys
);
  localparam int SUM_W = OFF_W + SHIFT + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = {1'b0, seg, {SHIFT{1'b0}}} + SUM_W'(off);
    phys = sum[PHYS_W-1:0];
  end
endmodule

// File: rtl/ssk_ptr_unit.sv
module ssk_ptr_unit #(
  parameter int OFF_W = 16,
  parameter int STEP  = 2,
  parameter int EMPTY = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_seg,
  input  logic [OFF_W-1:0] load_ptr,
  input  logic             dec,
  input  logic             inc,
  output logic [OFF_W-1:0] seg_q,
  output logic [OFF_W-1:0] ptr_q,
  output logic             is_empty,
  output logic             is_floor
);
  localparam logic [OFF_W-1:0] STEP_V  = OFF_W'(STEP);
  localparam logic [OFF_W-1:0] EMPTY_V = OFF_W'(EMPTY);
  localparam logic [OFF_W-1:0] FLOOR_V = EMPTY_V + STEP_V;
  localparam logic [OFF_W-1:0] MASK_V  = ~(STEP_V - OFF_W'(1));

  logic [OFF_W-1:0] seg_d, ptr_d;
  logic             seg_en, ptr_en;

  always_comb begin
    seg_d  = load_seg;
    seg_en = load;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (load) begin
      ptr_d  = load_ptr & MASK_V;
      ptr_en = 1'b1;
    end else if (dec) begin
      ptr_d  = ptr_q - STEP_V;
      ptr_en = 1'b1;
    end else if (inc) begin
      ptr_d  = ptr_q + STEP_V;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      ptr_q <= EMPTY_V;
    end else begin
      if (seg_en) seg_q <= seg_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign is_empty = (ptr_q == EMPTY_V);
  assign is_floor = (ptr_q == FLOOR_V);

  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && inc)) else $error("pointer moved both ways"); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (ptr_q == $past(ptr_q) + STEP_V)) else $error("pop step wrong"); // R3
endmodule

// File: rtl/ssk_ctrl.sv
module ssk_ctrl
  import ssk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_pop,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              is_empty,
  input  logic              is_floor,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              done,
  output logic              ovf,
  output logic              unf,
  output logic              ptr_dec,
  output logic              ptr_inc,
  output logic              cfg_ok,
  output logic [((DATA_W/BYTE_W) > 1 ? $clog2(DATA_W/BYTE_W) : 1)-1:0] byte_idx,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] pop_word
);
  localparam int WORD_BYTES = DATA_W / BYTE_W;
  localparam int IDX_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

  ssk_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              ovf_q, ovf_d, unf_q, unf_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    word_d  = word_q;
    rd_d    = rd_q;
    ovf_d   = ovf_q;
    unf_d   = unf_q;
    ptr_dec = 1'b0;
    ptr_inc = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          idx_d = '0;
          ovf_d = 1'b0;
          unf_d = 1'b0;
          if (cmd_pop) begin
            if (is_empty) begin
              unf_d   = 1'b1;
              state_d = ST_FIN;
            end else begin
              state_d = ST_RD;
            end
          end else if (is_floor) begin
            ovf_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            ptr_dec = 1'b1;
            word_d  = cmd_wdata;
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (idx_q == LAST) state_d = ST_FIN;
        else               idx_d   = idx_q + IDX_W'(1);
      end
      ST_RD: state_d = ST_RWAIT;
      ST_RWAIT: begin
        if (mem_rvalid) begin
          rd_d[idx_q*BYTE_W +: BYTE_W] = mem_rdata;
          if (idx_q == LAST) begin
            ptr_inc = 1'b1;
            state_d = ST_FIN;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_RD;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      rd_q    <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      rd_q    <= rd_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign ovf       = done && ovf_q;
  assign unf       = done && unf_q;
  assign cfg_ok    = (state_q == ST_IDLE) && !cmd_valid;
  assign byte_idx  = idx_q;
  assign mem_we    = (state_q == ST_WR);
  assign mem_re    = (state_q == ST_RD);
  assign mem_wdata = word_q[idx_q*BYTE_W +: BYTE_W];
  assign pop_word  = rd_q;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)) else $error("read and write together"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("busy after done"); // R7
endmodule

// File: rtl/seg_stack_engine.sv
module seg_stack_engine #(
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_pop,
  input  logic [DATA_W-1:0]        cmd_wdata,
  input  logic                     cfg_load,
  input  logic [OFF_W-1:0]         cfg_seg,
  input  logic [OFF_W-1:0]         cfg_ptr,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        pop_word,
  output logic                     overflow,
  output logic                     underflow,
  output logic [OFF_W-1:0]         sp_out,
  output logic [OFF_W-1:0]         ss_out,
  output logic [OFF_W+SHIFT-1:0]   mem_addr,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [BYTE_W-1:0]        mem_wdata,
  input  logic [BYTE_W-1:0]        mem_rdata,
  input  logic                     mem_rvalid
);
  localparam int PHYS_W     = OFF_W + SHIFT;
  localparam int WORD_BYTES = DATA_W / BYTE_W;
  localparam int IDX_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic             rst_meta, rst_s;
  logic             ptr_dec, ptr_inc, cfg_ok, is_empty, is_floor;
  logic [IDX_W-1:0] byte_idx;
  logic [OFF_W-1:0] seg_q, ptr_q, byte_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  ssk_ptr_unit #(.OFF_W(OFF_W), .STEP(WORD_BYTES), .EMPTY(0)) u_ptr (
    .clk(clk), .rst_n(rst_s),
    .load(cfg_load && cfg_ok), .load_seg(cfg_seg), .load_ptr(cfg_ptr),
    .dec(ptr_dec), .inc(ptr_inc),
    .seg_q(seg_q), .ptr_q(ptr_q), .is_empty(is_empty), .is_floor(is_floor)
  );

  ssk_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_wdata(cmd_wdata),
    .is_empty(is_empty), .is_floor(is_floor),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .busy(busy), .done(done), .ovf(overflow), .unf(underflow),
    .ptr_dec(ptr_dec), .ptr_inc(ptr_inc), .cfg_ok(cfg_ok),
    .byte_idx(byte_idx), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .pop_word(pop_word)
  );

  assign byte_off = ptr_q + OFF_W'(byte_idx);

  ssk_addr_gen #(.OFF_W(OFF_W), .SHIFT(SHIFT), .PHYS_W(PHYS_W)) u_addr (
    .seg(seg_q), .off(byte_off), .phys(mem_addr)
  );

  assign sp_out = ptr_q;
  assign ss_out = seg_q;

  AST_BYTE_ORDER: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + PHYS_W'(1)))
    else $error("high byte not above low byte"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_s)
    (done && overflow) |-> (!$past(mem_we) && $stable(sp_out)))
    else $error("refused push touched state"); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_s)
    (done && underflow) |-> (!$past(mem_re) && $stable(sp_out)))
    else $error("refused pop touched state"); // R5
endmodule

// File: tb/tb_seg_stack_engine.sv
module tb_seg_stack_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_pop = 1'b0, cfg_load = 1'b0;
  logic [15:0] cmd_wdata = '0, cfg_seg = '0, cfg_ptr = '0;
  logic        busy, done, overflow, underflow, mem_we, mem_re;
  logic [15:0] pop_word, sp_out, ss_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  int checks = 0, failures = 0, cycles = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, rd_lat = 1, pend = 0;
  logic [19:0] pend_addr = '0, last_wr = '0, prev_wr = '0;
  logic [7:0]  mem [int];
  bit          seen_ovf, seen_unf;
  logic [15:0] seen_word;

  always #10 clk = ~clk;

  seg_stack_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
    .cmd_wdata(cmd_wdata), .cfg_load(cfg_load), .cfg_seg(cfg_seg), .cfg_ptr(cfg_ptr),
    .busy(busy), .done(done), .pop_word(pop_word), .overflow(overflow),
    .underflow(underflow), .sp_out(sp_out), .ss_out(ss_out), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rvalid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      prev_wr <= last_wr;
      last_wr <= mem_addr;
    end
    if (mem_re) begin
      rd_cnt    <= rd_cnt + 1;
      pend_addr <= mem_addr;
      pend      <= rd_lat;
    end else if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(int'(pend_addr)) ? mem[int'(pend_addr)] : 8'h00;
      end
    end
  end

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'h0} + {4'h0, o});
  endfunction

  function automatic logic [7:0] peek(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] s, input logic [15:0] p);
    @(negedge clk);
    cfg_load = 1'b1; cfg_seg = s; cfg_ptr = p;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic do_cmd(input bit pop, input logic [15:0] d);
    int guard;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = pop; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    seen_ovf = overflow; seen_unf = underflow; seen_word = pop_word;
    @(negedge clk);
  endtask

  // op: 0 push, 1 pop, 2 load ; {op, arg, arg2/exp_word, exp_sp, {ovf,unf}}
  localparam int NV = 16;
  localparam logic [51:0] VEC [NV] = '{
    {2'd2, 16'h0105, 16'h0000, 16'h0000, 2'b00},
    {2'd0, 16'h1234, 16'h0000, 16'hFFFE, 2'b00},
    {2'd0, 16'hBBAA, 16'h0000, 16'hFFFC, 2'b00},
    {2'd0, 16'h00FF, 16'h0000, 16'hFFFA, 2'b00},
    {2'd1, 16'h0000, 16'h00FF, 16'hFFFC, 2'b00},
    {2'd0, 16'h5A5A, 16'h0000, 16'hFFFA, 2'b00},
    {2'd1, 16'h0000, 16'h5A5A, 16'hFFFC, 2'b00},
    {2'd1, 16'h0000, 16'hBBAA, 16'hFFFE, 2'b00},
    {2'd1, 16'h0000, 16'h1234, 16'h0000, 2'b00},
    {2'd1, 16'h0000, 16'h0000, 16'h0000, 2'b01},
    {2'd2, 16'h2000, 16'h0006, 16'h0006, 2'b00},
    {2'd0, 16'hC0DE, 16'h0000, 16'h0004, 2'b00},
    {2'd0, 16'hBEEF, 16'h0000, 16'h0002, 2'b00},
    {2'd0, 16'h7777, 16'h0000, 16'h0002, 2'b10},
    {2'd1, 16'h0000, 16'hBEEF, 16'h0004, 2'b00},
    {2'd2, 16'h0000, 16'h1235, 16'h1234, 2'b00}
  };

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] cur_seg;
    int w0, r0, d0;
    cur_seg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk("R4 sp", sp_out, 0);
    chk("R4 ss", ss_out, 0);
    chk("R4 busy/done", {busy, done}, 0);
    do_cmd(1'b0, 16'hA1B2);
    chk("R4 first push low at 0FFFE", peek(20'h0FFFE), 8'hB2);
    chk("R4 first push high at 0FFFF", peek(20'h0FFFF), 8'hA1);
    chk("R4 sp after first push", sp_out, 16'hFFFE);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [15:0] a, b, esp; logic [1:0] ef;
      {op, a, b, esp, ef} = VEC[i];
      if (op == 2'd2) begin
        do_load(a, b);
        cur_seg = a;
        chk("R9 load sp", sp_out, esp);
        chk("R9 load ss", ss_out, a);
      end else begin
        w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt;
        do_cmd(op == 2'd1, a);
        chk("R5/R6 flags", {seen_ovf, seen_unf}, ef);
        chk("R2/R3 sp", sp_out, esp);
        chk("R8 single done", done_cnt - d0, 1);
        if (ef == 2'b10) chk("R6 no write", wr_cnt - w0, 0);
        if (ef == 2'b01) chk("R5 no read", rd_cnt - r0, 0);
        if (op == 2'd1 && ef == 2'b00) chk("R3 pop word", seen_word, b);
        if (op == 2'd0 && ef == 2'b00) begin
          chk("R2 low byte", peek(phys(cur_seg, esp)), a[7:0]);
          chk("R2 high byte", peek(phys(cur_seg, esp) + 20'd1), a[15:8]);
          chk("R2 low written first", prev_wr, phys(cur_seg, esp));
          chk("R8 two write cycles", wr_cnt - w0, 2);
        end
      end
    end

    // R1 wrap of the physical address
    do_load(16'hFFFF, 16'h0000);
    do_cmd(1'b0, 16'h1357);
    chk("R1 wrap low 0FFEE", peek(20'h0FFEE), 8'h57);
    chk("R1 wrap high 0FFEF", peek(20'h0FFEF), 8'h13);

    // R8 slow read
    rd_lat = 4;
    do_cmd(1'b1, 16'h0000);
    chk("R8 slow read word", seen_word, 16'h1357);
    chk("R8 slow read sp", sp_out, 16'h0000);
    rd_lat = 1;

    // R7 commands while busy ignored
    do_load(16'h0300, 16'h0100);
    w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_wdata = 16'h4242;
    @(negedge clk);
    cmd_pop = 1'b1;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 sp after busy pop request", sp_out, 16'h00FE);
    chk("R7 one done", done_cnt - d0, 1);
    chk("R7 no read", rd_cnt - r0, 0);
    chk("R7 two writes", wr_cnt - w0, 2);

    // R9 load ignored while command valid
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b1; cfg_load = 1'b1; cfg_seg = 16'h7777; cfg_ptr = 16'h0040;
    @(negedge clk);
    cmd_valid = 1'b0; cfg_load = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 load blocked ss", ss_out, 16'h0300);
    chk("R3 pop after blocked load sp", sp_out, 16'h0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule